// File: doc/BRIEF.md
# Constant Buffer Upload and Binding Unit

This unit turns a stream of register writes into constant-buffer uploads and keeps a per-stage table of buffer bindings. Software first programs a base address, a buffer size and a write position. Every write to one of the aliased data registers becomes a single 32-bit store request, addressed at base plus position. Each accepted store moves the position forward by four bytes. A store is refused and flagged if the base address is zero, or if it would run past the programmed size.

Each shader stage has its own bind register. A write to it takes a snapshot of the current base address and size, together with the valid bit from the written word. The snapshot goes into that stage's table at the slot index carried by the word. A read port returns any table entry. Store requests leave through a valid/ready port. While a request is waiting there, the register interface stops accepting writes, so register traffic stays in order.

Top module: `cbuf_bind_unit`

## Requirements
- R1: After reset, no store request is pending, the register interface is ready, all three error flags are low, and every table entry reads back disabled with zero address and size.
- R2: Register indices: 0 is base address, 1 is buffer size, 2 is write position, and 16 to 31 are data aliases. A write to any data alias, with a nonzero base and room left, issues one request whose address is base + position and whose data is the written word.
- R3: Each accepted store advances the position by 4. Writing index 2 sets the position directly.
- R4: A data write for which position + 4 is greater than the size issues no request, pulses `err_bounds` for one cycle, and leaves the position unchanged.
- R5: A data write while the base is zero issues no request, pulses `err_zero_base` for one cycle, and leaves the position unchanged. This check takes precedence over R4, so at most one error flag is high at a time.
- R6: While `mem_req_valid` is high and `mem_req_ready` is low, the request address and data hold steady and `reg_wr_ready` is low. The request drops in the cycle after the handshake.
- R7: Indices 8 to 12 are the bind registers for the vertex, tessellation-control, tessellation-evaluation, geometry and fragment stages. In a bind word, bit 0 is the valid bit and bits 12:8 are the slot index. A bind write stores the valid bit, the current base and the current size into that stage's entry at that slot, and the read port returns them.
- R8: A bind write with a slot index of 18 or more pulses `err_slot` for one cycle and changes no table entry.
- R9: A bind write changes only its own stage and slot. Every other entry keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_idx | input | 6 | Register index |
| reg_wr_data | input | 32 | Register write data |
| reg_wr_ready | output | 1 | Write accepted when high together with the strobe |
| mem_req_valid | output | 1 | Store request pending |
| mem_req_ready | input | 1 | Memory side accepts the request |
| mem_req_addr | output | 32 | Store byte address |
| mem_req_data | output | 32 | Store data word |
| err_bounds | output | 1 | One-cycle pulse: store refused, out of bounds |
| err_zero_base | output | 1 | One-cycle pulse: store refused, zero base |
| err_slot | output | 1 | One-cycle pulse: bind slot out of range |
| rd_stage | input | 3 | Table read stage |
| rd_slot | input | 5 | Table read slot |
| rd_enabled | output | 1 | Entry valid bit |
| rd_addr | output | 32 | Entry base address |
| rd_size | output | 16 | Entry size |

## Verification
Store requests and error pulses are registered. They appear after the same clock edge that accepts the register write, so the bench samples them one time unit after that edge. It then checks that the error pulse has cleared by the following edge. Table updates also land on the accepting edge, and the read port is combinational, so readback is sampled after the read indices settle, away from any edge. During a stall the bench holds ready low for several cycles and checks the request at each one. It then confirms the request has dropped one edge after ready returns.

// File: rtl/cbu_pkg.sv
package cbu_pkg;
   localparam int REG_IDX_W = 6;
   localparam logic [REG_IDX_W-1:0] IDX_BASE  = 6'd0;
   localparam logic [REG_IDX_W-1:0] IDX_SIZE  = 6'd1;
   localparam logic [REG_IDX_W-1:0] IDX_POS   = 6'd2;
   localparam logic [REG_IDX_W-1:0] IDX_BIND0 = 6'd8;
   localparam logic [REG_IDX_W-1:0] IDX_DATA0 = 6'd16;
   localparam int BIND_VALID_BIT = 0;
   localparam int BIND_SLOT_LSB  = 8;
   localparam int BIND_SLOT_W    = 5;
   localparam int WORD_BYTES     = 4;
endpackage

// File: rtl/cbu_cfg_regs.sv
module cbu_cfg_regs #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [cbu_pkg::REG_IDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         pos_adv,
   output logic [ADDR_W-1:0]            base_q,
   output logic [SIZE_W-1:0]            size_q,
   output logic [SIZE_W-1:0]            pos_q
);
   import cbu_pkg::*;

   localparam logic [SIZE_W-1:0] STEP = SIZE_W'(WORD_BYTES);

   generate
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("ADDR_W must not exceed DATA_W");
      end
      if (SIZE_W > DATA_W) begin : g_bad_size
         $error("SIZE_W must not exceed DATA_W");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
         size_q <= '0;
         pos_q  <= '0;
      end else begin
         if (wr_en && wr_idx == IDX_BASE) base_q <= wr_data[ADDR_W-1:0];
         if (wr_en && wr_idx == IDX_SIZE) size_q <= wr_data[SIZE_W-1:0];
         if (wr_en && wr_idx == IDX_POS)  pos_q  <= wr_data[SIZE_W-1:0];
         else if (pos_adv)               pos_q  <= pos_q + STEP;
      end
   end
endmodule

// File: rtl/cbu_store_path.sv
module cbu_store_path #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_req,
   input  logic [DATA_W-1:0] st_data,
   input  logic [ADDR_W-1:0] base,
   input  logic [SIZE_W-1:0] size,
   input  logic [SIZE_W-1:0] pos,
   input  logic              mem_ready,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              pos_adv,
   output logic              err_bounds,
   output logic              err_zero
);
   import cbu_pkg::*;

   localparam int EXT_W = SIZE_W + 1;

   generate
      if (SIZE_W > ADDR_W) begin : g_bad_w
         $error("SIZE_W must not exceed ADDR_W");
      end
   endgenerate

   logic base_zero, out_of_bounds, go;
   logic [EXT_W-1:0] pos_end;

   always_comb begin
      pos_end       = {1'b0, pos} + EXT_W'(WORD_BYTES);
      base_zero     = (base == '0);
      out_of_bounds = pos_end > {1'b0, size};
      go            = st_req && !base_zero && !out_of_bounds;
      pos_adv       = go;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_valid  <= 1'b0;
         mem_addr   <= '0;
         mem_data   <= '0;
         err_bounds <= 1'b0;
         err_zero   <= 1'b0;
      end else begin
         if (go) begin
            mem_valid <= 1'b1;
            mem_addr  <= base + ADDR_W'(pos);
            mem_data  <= st_data;
         end else if (mem_valid && mem_ready) begin
            mem_valid <= 1'b0;
         end
         err_zero   <= st_req && base_zero;
         err_bounds <= st_req && !base_zero && out_of_bounds;
      end
   end
endmodule

// File: rtl/cbu_bind_table.sv
module cbu_bind_table #(
   parameter int NUM_STAGES = 5,
   parameter int NUM_SLOTS  = 18,
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int SLOT_W     = 5,
   parameter int STG_W      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bind_we,
   input  logic [STG_W-1:0]  bind_stage,
   input  logic [SLOT_W-1:0] bind_slot,
   input  logic              bind_valid,
   input  logic [ADDR_W-1:0] base,
   input  logic [SIZE_W-1:0] size,
   input  logic [STG_W-1:0]  rd_stage,
   input  logic [SLOT_W-1:0] rd_slot,
   output logic              rd_enabled,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [SIZE_W-1:0] rd_size,
   output logic              err_slot
);
   generate
      if (NUM_SLOTS > (1 << SLOT_W)) begin : g_bad_slots
         $error("NUM_SLOTS does not fit the slot field");
      end
      if (NUM_STAGES > (1 << STG_W)) begin : g_bad_stages
         $error("NUM_STAGES does not fit STG_W");
      end
   endgenerate

   logic              en_q   [NUM_STAGES][NUM_SLOTS];
   logic [ADDR_W-1:0] addr_q [NUM_STAGES][NUM_SLOTS];
   logic [SIZE_W-1:0] size_q [NUM_STAGES][NUM_SLOTS];

   logic slot_ok;
   assign slot_ok = (32'(bind_slot) < NUM_SLOTS);

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
         logic hit;
         assign hit = bind_we && slot_ok && (32'(bind_stage) == s) && (32'(bind_slot) == k);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q[s][k]   <= 1'b0;
               addr_q[s][k] <= '0;
               size_q[s][k] <= '0;
            end else if (hit) begin
               en_q[s][k]   <= bind_valid;
               addr_q[s][k] <= base;
               size_q[s][k] <= size;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_slot <= 1'b0;
      else        err_slot <= bind_we && !slot_ok;
   end

   always_comb begin
      rd_enabled = 1'b0;
      rd_addr    = '0;
      rd_size    = '0;
      for (int s = 0; s < NUM_STAGES; s++) begin
         for (int k = 0; k < NUM_SLOTS; k++) begin
            if (32'(rd_stage) == s && 32'(rd_slot) == k) begin
               rd_enabled = en_q[s][k];
               rd_addr    = addr_q[s][k];
               rd_size    = size_q[s][k];
            end
         end
      end
   end
endmodule

// File: rtl/cbuf_bind_unit.sv
module cbuf_bind_unit #(
   parameter int ADDR_W     = 32,
   parameter int SIZE_W     = 16,
   parameter int DATA_W     = 32,
   parameter int NUM_STAGES = 5,
   parameter int NUM_SLOTS  = 18,
   parameter int NUM_ALIAS  = 16,
   parameter int STG_W      = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_wr_en,
   input  logic [cbu_pkg::REG_IDX_W-1:0]  reg_wr_idx,
   input  logic [DATA_W-1:0]              reg_wr_data,
   output logic                           reg_wr_ready,
   output logic                           mem_req_valid,
   input  logic                           mem_req_ready,
   output logic [ADDR_W-1:0]              mem_req_addr,
   output logic [DATA_W-1:0]              mem_req_data,
   output logic                           err_bounds,
   output logic                           err_zero_base,
   output logic                           err_slot,
   input  logic [STG_W-1:0]               rd_stage,
   input  logic [cbu_pkg::BIND_SLOT_W-1:0] rd_slot,
   output logic                           rd_enabled,
   output logic [ADDR_W-1:0]              rd_addr,
   output logic [SIZE_W-1:0]              rd_size
);
   import cbu_pkg::*;

   localparam int ALIAS_END = int'(IDX_DATA0) + NUM_ALIAS;
   localparam int BIND_END  = int'(IDX_BIND0) + NUM_STAGES;

   generate
      if (ALIAS_END > (1 << REG_IDX_W)) begin : g_bad_alias
         $error("Alias range exceeds the register index space");
      end
      if (BIND_END > int'(IDX_DATA0)) begin : g_bad_bind
         $error("Bind registers overlap the data aliases");
      end
      if (BIND_SLOT_LSB + BIND_SLOT_W > DATA_W) begin : g_bad_field
         $error("Bind slot field exceeds the data word");
      end
   endgenerate

   logic              accept, is_data, is_bind, pos_adv;
   logic [ADDR_W-1:0] base_q;
   logic [SIZE_W-1:0] size_q;
   logic [SIZE_W-1:0] pos_q;
   logic [STG_W-1:0]  bind_stage;

   assign reg_wr_ready = !mem_req_valid;
   assign accept       = reg_wr_en && reg_wr_ready;
   assign is_data      = (int'(reg_wr_idx) >= int'(IDX_DATA0)) && (int'(reg_wr_idx) < ALIAS_END);
   assign is_bind      = (int'(reg_wr_idx) >= int'(IDX_BIND0)) && (int'(reg_wr_idx) < BIND_END);
   assign bind_stage   = STG_W'(reg_wr_idx - IDX_BIND0);

   cbu_cfg_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_idx(reg_wr_idx),
      .wr_data(reg_wr_data), .pos_adv(pos_adv),
      .base_q(base_q), .size_q(size_q), .pos_q(pos_q));

   cbu_store_path #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) i_store (
      .clk(clk), .rst_n(rst_n), .st_req(accept && is_data), .st_data(reg_wr_data),
      .base(base_q), .size(size_q), .pos(pos_q), .mem_ready(mem_req_ready),
      .mem_valid(mem_req_valid), .mem_addr(mem_req_addr), .mem_data(mem_req_data),
      .pos_adv(pos_adv), .err_bounds(err_bounds), .err_zero(err_zero_base));

   cbu_bind_table #(.NUM_STAGES(NUM_STAGES), .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W),
                    .SIZE_W(SIZE_W), .SLOT_W(BIND_SLOT_W), .STG_W(STG_W)) i_table (
      .clk(clk), .rst_n(rst_n), .bind_we(accept && is_bind), .bind_stage(bind_stage),
      .bind_slot(reg_wr_data[BIND_SLOT_LSB +: BIND_SLOT_W]),
      .bind_valid(reg_wr_data[BIND_VALID_BIT]),
      .base(base_q), .size(size_q), .rd_stage(rd_stage), .rd_slot(rd_slot),
      .rd_enabled(rd_enabled), .rd_addr(rd_addr), .rd_size(rd_size), .err_slot(err_slot));
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_ready,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic [DATA_W-1:0] mem_req_data,
   input logic              err_bounds,
   input logic              err_zero_base,
   input logic              err_slot,
   input logic [ADDR_W-1:0] base_q,
   input logic [SIZE_W-1:0] size_q,
   input logic [SIZE_W-1:0] pos_q
);
   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data))); // R6
   AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !reg_wr_ready); // R6
   AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_bounds, err_zero_base, err_slot})); // R5
   AST_REFUSED_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (err_bounds || err_zero_base) |-> (!mem_req_valid && $stable(pos_q))); // R4
   AST_ADDR_FROM_POS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> (mem_req_addr == $past(base_q) + ADDR_W'($past(pos_q)))); // R2
   AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> (pos_q == $past(pos_q) + SIZE_W'(4))); // R3
   AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req_valid) |-> (pos_q <= size_q)); // R4
endmodule

bind cbuf_bind_unit cbu_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr_ready(reg_wr_ready), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
   .err_bounds(err_bounds), .err_zero_base(err_zero_base), .err_slot(err_slot),
   .base_q(base_q), .size_q(size_q), .pos_q(pos_q));

// File: tb/test_cbuf_bind_unit.sv
module test_cbuf_bind_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [5:0]  reg_wr_idx = '0;
   logic [31:0] reg_wr_data = '0;
   logic        reg_wr_ready;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic [31:0] mem_req_addr, mem_req_data;
   logic        err_bounds, err_zero_base, err_slot;
   logic [2:0]  rd_stage = '0;
   logic [4:0]  rd_slot = '0;
   logic        rd_enabled;
   logic [31:0] rd_addr;
   logic [15:0] rd_size;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cbuf_bind_unit i_cbuf_bind_unit (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [5:0] idx, input logic [31:0] data);
      @(negedge clk);
      while (!reg_wr_ready) @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_idx = idx; reg_wr_data = data;
      @(posedge clk); #1;
      reg_wr_en = 1'b0;
   endtask

   function automatic logic [31:0] exp_base(int s, int k);
      return 32'h1000_0000 + 32'(s) * 32'h100 + 32'(k) * 32'h10;
   endfunction
   function automatic logic [15:0] exp_size(int s, int k);
      return 16'(s * 32 + k + 1);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 valid", 32'(mem_req_valid), 0);
      check("R1 ready", 32'(reg_wr_ready), 1);
      check("R1 errs", 32'({err_bounds, err_zero_base, err_slot}), 0);
      check("R1 entry en", 32'(rd_enabled), 0);
      check("R1 entry addr", rd_addr, 0);

      // R5 zero base after reset
      reg_wr(6'd1, 32'h40);
      reg_wr(6'd20, 32'hDEAD);
      check("R5 zero err", 32'(err_zero_base), 1);
      check("R5 no req", 32'(mem_req_valid), 0);

      // R6 stall
      reg_wr(6'd0, 32'h2000);
      @(negedge clk); mem_req_ready = 1'b0;
      reg_wr(6'd19, 32'hA000_0000);
      check("R2 first addr", mem_req_addr, 32'h2000);
      check("R2 first data", mem_req_data, 32'hA000_0000);
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); #1;
         check("R6 hold valid", 32'(mem_req_valid), 1);
         check("R6 hold addr", mem_req_addr, 32'h2000);
         check("R6 not ready", 32'(reg_wr_ready), 0);
      end
      @(negedge clk); mem_req_ready = 1'b1;
      @(posedge clk); #1;
      check("R6 drop", 32'(mem_req_valid), 0);

      // R2/R3 sweep over all aliases
      for (int i = 1; i < 16; i++) begin
         reg_wr(6'(16 + ((i * 5) % 16)), 32'hA000_0000 + 32'(i));
         check("R2 valid", 32'(mem_req_valid), 1);
         check("R3 addr", mem_req_addr, 32'h2000 + 32'(4 * i));
         check("R2 data", mem_req_data, 32'hA000_0000 + 32'(i));
         check("R4 no err", 32'(err_bounds), 0);
      end
      // R4 full
      reg_wr(6'd31, 32'h1);
      check("R4 bounds err", 32'(err_bounds), 1);
      check("R4 no req", 32'(mem_req_valid), 0);
      @(posedge clk); #1;
      check("R4 pulse", 32'(err_bounds), 0);
      // R3 direct position write
      reg_wr(6'd2, 32'h3C);
      reg_wr(6'd16, 32'h55);
      check("R3 pos write addr", mem_req_addr, 32'h203C);
      reg_wr(6'd2, 32'h3E);
      reg_wr(6'd17, 32'h66);
      check("R4 partial err", 32'(err_bounds), 1);
      check("R4 partial no req", 32'(mem_req_valid), 0);
      // R5 precedence and position kept
      reg_wr(6'd2, 32'h3C);
      reg_wr(6'd0, 32'h0);
      reg_wr(6'd18, 32'h77);
      check("R5 err", 32'(err_zero_base), 1);
      check("R5 only one", 32'(err_bounds), 0);
      reg_wr(6'd0, 32'h3000);
      reg_wr(6'd18, 32'h78);
      check("R5 pos kept", mem_req_addr, 32'h303C);

      // R7 bind sweep
      for (int s = 0; s < 5; s++) begin
         for (int k = 0; k < 18; k++) begin
            reg_wr(6'd0, exp_base(s, k));
            reg_wr(6'd1, 32'(exp_size(s, k)));
            reg_wr(6'(8 + s), (32'(k) << 8) | 32'((s + k) % 2));
            if (k == 0) check("R7 no slot err", 32'(err_slot), 0);
         end
      end
      // R8 out-of-range slots
      reg_wr(6'd0, 32'hFFFF_0000);
      for (int k = 18; k < 32; k++) begin
         reg_wr(6'd10, (32'(k) << 8) | 32'h1);
         check("R8 slot err", 32'(err_slot), 1);
      end
      // R7/R8/R9 readback
      for (int s = 0; s < 5; s++) begin
         for (int k = 0; k < 18; k++) begin
            @(negedge clk); rd_stage = 3'(s); rd_slot = 5'(k);
            #1;
            check("R7 en", 32'(rd_enabled), 32'((s + k) % 2));
            check("R9 addr", rd_addr, exp_base(s, k));
            check("R9 size", 32'(rd_size), 32'(exp_size(s, k)));
         end
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule